// File: doc/BRIEF.md
# Received Port-Write Capture Buffer

This block takes one incoming maintenance port-write payload off a simple word stream and keeps it in a small word buffer. It holds that payload until a host has read it and released it. The ingress side presents 32-bit words qualified by a valid strobe. A start marker flags the first word of a packet and an end marker flags the last. A start and an end marker on the same beat make a one-word packet.

The host sees three things through a 32-bit memory-mapped port: a control register, a status register and a window onto the stored words. Reads are combinational from the address. Writes take effect at the clock edge.

While a packet is being stored, or is stored and not yet released, the block reports busy. A packet that starts while the block is busy is dropped whole. A packet that starts while the enable bit is off is also dropped whole. The host frees the buffer with a write-one clear command. The payload length is reported in double words, computed from the number of words the packet carried.

Top module: `pw_rx_capture`

## Requirements
- R1: After a synchronous active-low reset, the control register at byte address 0x10250 reads 0x00000001 (enable on) and the status register at 0x10254 reads 0x00000000.
- R2: Control bit 0 is the enable and is writable. A packet whose start beat arrives while the enable reads 0 is dropped: busy stays 0 and the buffer words are untouched.
- R3: Control bit 1 is the clear command. It and control bits 31:2 always read 0.
- R4: Status bit 0 (busy) becomes 1 in the cycle after an accepted start beat. It stays 1 through the capture and after the end beat, until a clear. Status bit 1 and bits 31:6 read 0.
- R5: The word with index i of the captured packet (i from 0 to 15) reads back at byte address 0x10260 + 4*i. Word 0 is the start beat.
- R6: Status bits 5:2 give the size code, which appears in the cycle after the end beat. For n received words the code is 0 when n is 1, and ceil(n/2) otherwise.
- R7: A write with control bit 1 set makes busy 0 and the size code 0 in the next cycle. If a capture is in progress, it is abandoned and its remaining beats are ignored.
- R8: A start beat that arrives while busy is 1 (with no clear in that cycle) is dropped whole. Busy, the size code and all buffer words keep their values.
- R9: Words past the sixteenth are discarded without changing the buffer. The size code saturates at 15.
- R10: When a clear and an enabled start beat arrive in the same cycle, the clear is applied first and the new packet is captured.
- R11: Writes to the status register or the buffer window have no effect. Reads at any address other than the control register, the status register or a word-aligned address in 0x10260..0x1029C return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Ingress word valid |
| in_sop | input | 1 | First word of a packet (qualified by in_valid) |
| in_eop | input | 1 | Last word of a packet (qualified by in_valid) |
| in_data | input | 32 | Ingress payload word |
| host_addr | input | 20 | Host byte address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational from host_addr) |

## Verification
The bench targets the following corner cases:

- **Start beat while a packet is held.** A design that overwrote the buffer here would lose the unread payload.
- **Over-long packet.** A design without a write-index guard would wrap around and clobber word 0. One that did not clamp the size code would report a wrapped length.
- **Clear and start in the same cycle.** Getting the priority wrong would drop the new packet.
- **Clear in the middle of a capture.** A design that did not abandon the capture would leave busy set, or would report a size for a half-stored packet.

Single-word, odd and even word counts exercise the size-code rounding, including the special code 0 for a single word. Disabled packets, writes to read-only locations and unmapped reads each have their visible result compared against a behavioural model on every cycle.

// File: rtl/pw_rx_pkg.sv
// pw_rx_pkg: shared widths, address map and the size-code function for the
// port-write capture buffer. Assumes byte addressing with 32-bit words.
package pw_rx_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 20;
    localparam int BUF_WORDS = 16;
    localparam int IDX_W     = $clog2(BUF_WORDS);
    localparam int SIZE_W    = 4;
    localparam int SIZE_MAX  = (1 << SIZE_W) - 1;
    // the counter must reach the word count at which the code saturates
    localparam int CNT_W     = $clog2(2 * SIZE_MAX + 2);
    localparam int CNT_MAX   = (1 << CNT_W) - 1;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 20'h10250;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 20'h10254;
    localparam logic [ADDR_W-1:0] BUF_ADDR  = 20'h10260;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_CLR_BIT  = 1;
    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_SIZE_LSB = 2;

    // Double-word size code for a count of received words; 0 encodes one word.
    function automatic logic [SIZE_W-1:0] size_code(input logic [CNT_W-1:0] words);
        logic [CNT_W:0] dw;
        dw = ({1'b0, words} + 1'b1) >> 1;
        if (words <= 1)
            return '0;
        else if (dw > (CNT_W+1)'(SIZE_MAX))
            return SIZE_W'(SIZE_MAX);
        else
            return dw[SIZE_W-1:0];
    endfunction
endpackage

// File: rtl/pw_rx_capture_ctl.sv
// pw_rx_capture_ctl: decides acceptance of a packet, tracks the capture in
// progress and holds busy and the size code. Assumes in_sop and in_eop are
// only meaningful while in_valid is high; a clear is a one-cycle pulse.
module pw_rx_capture_ctl
    import pw_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              enable,
    input  logic              clear,
    output logic              busy,
    output logic [SIZE_W-1:0] size,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx
);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(BUF_WORDS);
    localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(CNT_MAX);

    logic             capturing;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             sop_beat;
    logic             accept;
    logic             cont;

    // classify the current beat: new accepted packet or continuation
    always_comb begin
        sop_beat = in_valid && in_sop;
        accept   = sop_beat && enable && (clear || !busy);
        cont     = in_valid && !in_sop && capturing && !clear;
        cnt_next = (cnt == CNT_TOP) ? cnt : cnt + 1'b1;
        wr_en    = accept || (cont && (cnt < CNT_LIMIT));
        wr_idx   = accept ? '0 : cnt[IDX_W-1:0];
    end

    // capture state: clear first, then an accepted start or a continuation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            capturing <= 1'b0;
            cnt       <= '0;
            size      <= '0;
        end else begin
            if (clear) begin
                busy      <= 1'b0;
                capturing <= 1'b0;
                size      <= '0;
            end
            if (accept) begin
                busy      <= 1'b1;
                cnt       <= CNT_W'(1);
                capturing <= !in_eop;
                size      <= in_eop ? size_code(CNT_W'(1)) : '0;
            end else if (cont) begin
                cnt <= cnt_next;
                if (in_eop) begin
                    capturing <= 1'b0;
                    size      <= size_code(cnt_next);
                end
            end
        end
    end

    assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid && in_sop && enable));
    assert_disabled_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && !enable && !busy) |=> !busy);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !(in_valid && in_sop && enable)) |=> (!busy && size == '0));
    assert_clear_then_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && in_valid && in_sop && enable) |=> busy);
    assert_size_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (size == '0));
    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clear && in_valid && in_sop) |=> ($stable(size) && busy));
endmodule

// File: rtl/pw_rx_word_store.sv
// pw_rx_word_store: the payload word array with one write port and one
// combinational read port. Storage has no reset; unwritten words are unknown.
module pw_rx_word_store
    import pw_rx_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] words [BUF_WORDS];

    for (genvar g = 0; g < BUF_WORDS; g++) begin : g_word
        // one payload word, loaded when its index is written
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g)))
                words[g] <= wr_data;
        end
    end

    // read port selects the addressed word
    always_comb rd_data = words[rd_idx];
endmodule

// File: rtl/pw_rx_host_regs.sv
// pw_rx_host_regs: host address decode, the control register and the read
// mux. Assumes word-aligned accesses; anything unmapped reads as zero.
module pw_rx_host_regs
    import pw_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              busy,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] buf_word,
    output logic [IDX_W-1:0]  buf_idx,
    output logic              enable,
    output logic              clear,
    output logic [DATA_W-1:0] host_rdata
);
    localparam logic [ADDR_W-1:0] BUF_END = BUF_ADDR + ADDR_W'(4 * BUF_WORDS);

    logic              hit_ctrl;
    logic              hit_stat;
    logic              hit_buf;
    logic [ADDR_W-1:0] buf_ofs;

    // address decode
    always_comb begin
        hit_ctrl = (host_addr == CTRL_ADDR);
        hit_stat = (host_addr == STAT_ADDR);
        buf_ofs  = host_addr - BUF_ADDR;
        hit_buf  = (host_addr >= BUF_ADDR) && (host_addr < BUF_END) &&
                   (host_addr[1:0] == 2'b00);
        buf_idx  = buf_ofs[IDX_W+1:2];
        clear    = host_we && hit_ctrl && host_wdata[CTRL_CLR_BIT];
    end

    // enable bit of the control register
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= 1'b1;
        else if (host_we && hit_ctrl)
            enable <= host_wdata[CTRL_EN_BIT];
    end

    // read mux: control, status, buffer window, else zero
    always_comb begin
        host_rdata = '0;
        if (hit_ctrl) begin
            host_rdata[CTRL_EN_BIT] = enable;
        end else if (hit_stat) begin
            host_rdata[STAT_BUSY_BIT] = busy;
            host_rdata[STAT_SIZE_LSB +: SIZE_W] = size;
        end else if (hit_buf) begin
            host_rdata = buf_word;
        end
    end

    assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && hit_ctrl) |=> (enable == $past(host_wdata[CTRL_EN_BIT])));
    assert_enable_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && hit_ctrl) |=> $stable(enable));
    assert_ctrl_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctrl |-> (host_rdata[DATA_W-1:1] == '0));
endmodule

// File: rtl/pw_rx_capture.sv
// pw_rx_capture: top of the received port-write capture buffer. Joins the
// capture control, the word store and the host register decode.
module pw_rx_capture
    import pw_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    logic              enable;
    logic              clear;
    logic              busy;
    logic [SIZE_W-1:0] size;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;

    pw_rx_capture_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .enable   (enable),
        .clear    (clear),
        .busy     (busy),
        .size     (size),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx)
    );

    pw_rx_word_store u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (in_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    pw_rx_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .busy       (busy),
        .size       (size),
        .buf_word   (rd_data),
        .buf_idx    (rd_idx),
        .enable     (enable),
        .clear      (clear),
        .host_rdata (host_rdata)
    );
endmodule

// File: tb/pw_rx_capture_tb.sv
`timescale 1ns/1ps
module pw_rx_capture_tb;
    localparam logic [19:0] CTRL = 20'h10250;
    localparam logic [19:0] STAT = 20'h10254;
    localparam logic [19:0] BUFA = 20'h10260;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [31:0] in_data = '0;
    logic [19:0] host_addr = STAT;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference state
    bit          m_en, m_busy, m_cap;
    int          m_cnt, m_size;
    logic [31:0] m_buf [16];

    always #2.5 clk = ~clk;

    pw_rx_capture u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .host_addr(host_addr),
        .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    function automatic int code(int n);
        int c;
        if (n <= 1) return 0;
        c = (n + 1) / 2;
        return (c > 15) ? 15 : c;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // model step at each edge, then compare status whenever it is addressed
    always begin
        bit clr, en_old;
        @(posedge clk);
        if (!rst_n) begin
            m_en = 1; m_busy = 0; m_size = 0; m_cap = 0; m_cnt = 0;
        end else begin
            clr = host_we && host_addr == CTRL && host_wdata[1];
            en_old = m_en;
            if (host_we && host_addr == CTRL) m_en = host_wdata[0];
            if (clr) begin m_busy = 0; m_size = 0; m_cap = 0; end
            if (in_valid && in_sop) begin
                if (en_old && !m_busy) begin
                    m_buf[0] = in_data; m_cnt = 1; m_busy = 1;
                    if (in_eop) begin m_size = code(1); m_cap = 0; end
                    else m_cap = 1;
                end
            end else if (in_valid && m_cap) begin
                if (m_cnt < 16) m_buf[m_cnt] = in_data;
                if (m_cnt < 31) m_cnt++;
                if (in_eop) begin m_cap = 0; m_size = code(m_cnt); end
            end
        end
        #1;
        if (rst_n && host_addr == STAT && !done)
            chk("R4 R6 model status", host_rdata, 32'((m_size << 2) | int'(m_busy)));
    end

    task automatic rd(input logic [19:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_addr = STAT;
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0; host_addr = STAT;
    endtask

    task automatic send(int n, logic [31:0] seed, bit gaps);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == n - 1);
            in_data = seed + 32'(i);
            if (gaps) begin
                @(negedge clk);
                in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic chk_buf(string tag, int n, logic [31:0] seed);
        logic [31:0] d;
        for (int i = 0; i < n && i < 16; i++) begin
            rd(BUFA + 20'(4 * i), d);
            chk(tag, d, seed + 32'(i));
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(CTRL, d); chk("R1 ctrl reset", d, 32'h1);
        rd(STAT, d); chk("R1 stat reset", d, 32'h0);

        // R5 R6 single-word packet, code 0
        send(1, 32'hA000_0000, 0);
        rd(STAT, d); chk("R6 single word status", d, 32'h1);
        chk_buf("R5 single word", 1, 32'hA000_0000);

        // R8 start while busy is dropped
        send(3, 32'hB000_0000, 0);
        rd(STAT, d); chk("R8 status held", d, 32'h1);
        chk_buf("R8 buffer held", 1, 32'hA000_0000);

        // R7 clear, R3 clear bit reads 0
        wr(CTRL, 32'h3);
        rd(STAT, d); chk("R7 cleared status", d, 32'h0);
        rd(CTRL, d); chk("R3 ctrl readback", d, 32'h1);

        // R4 R6 five words with gaps: code 3
        send(5, 32'hC000_0010, 1);
        rd(STAT, d); chk("R6 five words", d, 32'h0000_000D);
        chk_buf("R5 five words", 5, 32'hC000_0010);
        wr(CTRL, 32'h3);

        // R2 disabled drop
        wr(CTRL, 32'h0);
        rd(CTRL, d); chk("R2 enable off", d, 32'h0);
        send(2, 32'hD000_0000, 0);
        rd(STAT, d); chk("R2 no capture", d, 32'h0);
        chk_buf("R2 buffer untouched", 5, 32'hC000_0010);
        wr(CTRL, 32'h1);

        // R6 two words: code 1
        send(2, 32'hE000_0000, 0);
        rd(STAT, d); chk("R6 two words", d, 32'h5);
        wr(CTRL, 32'h3);

        // R5 R6 full 16 words: code 8
        send(16, 32'h1000_0000, 0);
        rd(STAT, d); chk("R6 sixteen words", d, 32'h21);
        chk_buf("R5 sixteen words", 16, 32'h1000_0000);
        wr(CTRL, 32'h3);

        // R9 40-word packet: saturate, extra words dropped
        send(40, 32'h2000_0000, 0);
        rd(STAT, d); chk("R9 saturated size", d, 32'h3D);
        chk_buf("R9 first sixteen kept", 16, 32'h2000_0000);

        // R10 clear and start in one cycle
        @(negedge clk);
        host_addr = CTRL; host_wdata = 32'h3; host_we = 1'b1;
        in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = 32'h3000_0042;
        @(negedge clk);
        host_we = 1'b0; host_addr = STAT;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        rd(STAT, d); chk("R10 accepted after clear", d, 32'h1);
        chk_buf("R10 word", 1, 32'h3000_0042);

        // R11 writes to read-only locations, unmapped reads
        wr(STAT, 32'hFFFF_FFFF);
        wr(BUFA, 32'h5555_5555);
        rd(STAT, d); chk("R11 status unchanged", d, 32'h1);
        rd(BUFA, d); chk("R11 buffer unchanged", d, 32'h3000_0042);
        rd(20'h10258, d); chk("R11 gap read", d, 32'h0);
        rd(20'h102A0, d); chk("R11 past window", d, 32'h0);
        rd(20'h10262, d); chk("R11 unaligned", d, 32'h0);
        rd(20'h00000, d); chk("R11 low address", d, 32'h0);

        // R7 clear mid-capture abandons the packet
        wr(CTRL, 32'h3);
        @(negedge clk);
        in_valid = 1'b1; in_sop = 1'b1; in_data = 32'h4000_0000;
        @(negedge clk);
        in_sop = 1'b0; in_data = 32'h4000_0001;
        @(negedge clk);
        in_valid = 1'b0;
        host_addr = CTRL; host_wdata = 32'h3; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0; host_addr = STAT;
        in_valid = 1'b1; in_eop = 1'b1; in_data = 32'h4000_0002;
        @(negedge clk);
        in_valid = 1'b0; in_eop = 1'b0;
        rd(STAT, d); chk("R7 abandoned capture", d, 32'h0);
        chk_buf("R7 stored words before clear", 2, 32'h4000_0000);

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule